// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block produces the timing reference for a two-output pulse-width modulator. The input clock first passes through a two-stage prescaler. Each stage is set by its own 3-bit field, and the two ratios multiply. The result is a one-cycle tick that advances a 16-bit counter. The counter can count upward, count downward, count up and then down, or hold still. Whenever the counter passes through zero or through the active period, a one-cycle event strobe goes out to the compare logic further down the chain.

A single write port loads two words. One is the control word, which holds the mode, the period-load policy and the two divider fields. The other is the period. Period writes either take effect at once or go into a shadow copy, and the shadow is transferred to the active period on the next zero event. Shadow loading lets software change the period at any time without cutting a PWM cycle short.

Count direction is kept by a two-state machine with the states `DIR_UP` and `DIR_DOWN`. The mode decides the transitions. Up mode forces `DIR_UP`, and down mode forces `DIR_DOWN`. In up-down mode the transition *turn-at-top* (`DIR_UP`→`DIR_DOWN`) fires when the counter is at or above the period on a tick. The transition *turn-at-bottom* (`DIR_DOWN`→`DIR_UP`) fires when the counter is zero on a tick. Frozen mode keeps the state unchanged.

Top module: `pwm_timebase`

## Requirements
- R1: Synchronous reset (`rst` high at a rising edge) clears the counter, the control word and both period registers. After reset the mode is up-count, both divider fields are zero, the period load is shadowed and the period is 0.
- R2: Control bits 9:7 (value H) divide by 1 when H=0 and by 2·H otherwise. Control bits 12:10 (value L) divide by 2^L. The counter changes only on a tick, and a tick comes once every (H-divider × L-divider) clock cycles.
- R3: With control bits 1:0 = 00 (up), each tick increments the counter. A tick with the counter at or above the period loads 0 instead. The sequence runs 0..P, then 0, including P = 0xFFFF.
- R4: With mode 01 (down), each tick decrements the counter. A tick at zero loads the period, so the sequence runs P..0, then P.
- R5: With mode 10 (up-down), the counter counts up to P and then down to 0, turning at both ends (…P-1, P, P-1…1, 0, 1…). With P = 0 it stays at 0.
- R6: With mode 11 (frozen), the counter holds its value and neither event strobe is asserted.
- R7: `zero_evt` is high for exactly the clock cycle in which a tick occurs while the counter is 0 and the mode is not frozen.
- R8: `prd_evt` is high for exactly the clock cycle in which a tick occurs while the counter equals the active period and the mode is not frozen.
- R9: With control bit 3 = 1 (immediate load), a period write replaces the active period (and the shadow) at the next edge. Ticks after that use the new value.
- R10: With control bit 3 = 0 (shadow load), a period write changes only the shadow. The active period takes the shadow value on a `zero_evt` cycle. The count decision on that same tick already uses the new period, and the active period is otherwise unchanged.
- R11: `wr_en` with `wr_sel` = 0 writes the control word, and with `wr_sel` = 1 writes the period. Either write takes effect at the next clock edge.
- R12: In up mode, if an immediate write leaves the counter above the new period, the next tick wraps the counter to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_sel | input | 1 | Write target: 0 control word, 1 period |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current counter value |
| zero_evt | output | 1 | Counter-at-zero event strobe |
| prd_evt | output | 1 | Counter-at-period event strobe |

## Verification
Some properties are checked by assertions on every cycle. The counter never moves between ticks, and it holds while frozen. A zero tick in down mode reloads exactly the active period. Immediate writes land in the active period on the next cycle, while in shadow mode the active period moves only by copying the shadow on a zero event. Strobes stay quiet while frozen, and the prescaler ticks every cycle when both fields are zero.

Other behaviour only the bench scenarios can show, because they need whole sequences compared against a reference model. These include the actual divide ratios for mixed field values, the turning points in up-down mode, the wrap at 0xFFFF, the wrap after the period is lowered below the count, and reset in the middle of a run.

// File: rtl/pwm_tbase_pkg.sv
package pwm_tbase_pkg;

    // Counter mode field encoding (control bits 1:0)
    typedef enum logic [1:0] {
        MODE_UP     = 2'b00,
        MODE_DOWN   = 2'b01,
        MODE_UPDOWN = 2'b10,
        MODE_FROZEN = 2'b11
    } cnt_mode_e;

    // Direction state of the counter machine
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_state_e;

    // Control word field positions
    localparam int MODE_LSB = 0;
    localparam int PLD_BIT  = 3;
    localparam int HS_LSB   = 7;
    localparam int LO_LSB   = 10;
    localparam int FIELD_W  = 3;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int FIELD_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [FIELD_W-1:0] hs_sel,
    input  logic [FIELD_W-1:0] lo_sel,
    output logic               tick
);
    localparam int HS_MAX  = 2 * ((1 << FIELD_W) - 1);
    localparam int LO_MAX  = 1 << ((1 << FIELD_W) - 1);
    localparam int DIV_MAX = HS_MAX * LO_MAX;
    localparam int CNT_W   = $clog2(DIV_MAX + 1);

    logic [CNT_W-1:0] hs_div;
    logic [CNT_W-1:0] div_total;
    logic [CNT_W-1:0] pcnt_q;

    always_comb begin
        if (hs_sel == '0) begin
            hs_div = CNT_W'(1);
        end else begin
            hs_div = CNT_W'({hs_sel, 1'b0});
        end
        div_total = hs_div << lo_sel;
        // >= keeps the tick alive if the ratio shrinks below the running count
        tick = (pcnt_q >= (div_total - CNT_W'(1)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt_q <= '0;
        end else if (tick) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + CNT_W'(1);
        end
    end

    AST_UNITY_DIV_TICKS: assert property (@(posedge clk) disable iff (rst)
        (hs_sel == '0 && lo_sel == '0) |-> tick); // R2

endmodule

// File: rtl/pwm_period_reg.sv
module pwm_period_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_prd,
    input  logic [W-1:0] wr_data,
    input  logic         imm_mode,
    input  logic         load_req,
    output logic [W-1:0] act_prd,
    output logic [W-1:0] act_next
);
    logic [W-1:0] shadow_q;
    logic [W-1:0] shadow_d;

    always_comb begin
        shadow_d = wr_prd ? wr_data : shadow_q;
        if (wr_prd && imm_mode) begin
            act_next = wr_data;
        end else if (load_req && !imm_mode) begin
            act_next = shadow_q;
        end else begin
            act_next = act_prd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_prd  <= '0;
            shadow_q <= '0;
        end else begin
            act_prd  <= act_next;
            shadow_q <= shadow_d;
        end
    end

    AST_IMM_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr_prd && imm_mode) |=> (act_prd == $past(wr_data))); // R9

    AST_SHADOW_COPY: assert property (@(posedge clk) disable iff (rst)
        (load_req && !imm_mode) |=> (act_prd == $past(shadow_q))); // R10

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!imm_mode && !load_req) |=> $stable(act_prd)); // R10

endmodule

// File: rtl/pwm_dir_counter.sv
module pwm_dir_counter
    import pwm_tbase_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  cnt_mode_e    mode,
    input  logic [W-1:0] prd_next,
    input  logic [W-1:0] act_prd,
    output logic [W-1:0] cnt,
    output logic         zero_evt,
    output logic         prd_evt
);
    dir_state_e   dir_q, dir_d;
    logic [W-1:0] cnt_d;
    logic         run;

    assign run = tick && (mode != MODE_FROZEN);

    // next-state and next-count
    always_comb begin
        dir_d = dir_q;
        cnt_d = cnt;
        if (run) begin
            unique case (mode)
                MODE_UP: begin
                    dir_d = DIR_UP;
                    cnt_d = (cnt >= prd_next) ? '0 : cnt + W'(1);
                end
                MODE_DOWN: begin
                    dir_d = DIR_DOWN;
                    cnt_d = (cnt == '0) ? prd_next : cnt - W'(1);
                end
                MODE_UPDOWN: begin
                    unique case (dir_q)
                        DIR_UP: begin
                            if (cnt >= prd_next) begin
                                dir_d = DIR_DOWN;            // turn-at-top
                                cnt_d = (cnt == '0) ? '0 : cnt - W'(1);
                            end else begin
                                cnt_d = cnt + W'(1);
                            end
                        end
                        DIR_DOWN: begin
                            if (cnt == '0) begin
                                dir_d = DIR_UP;              // turn-at-bottom
                                cnt_d = (prd_next == '0) ? '0 : W'(1);
                            end else begin
                                cnt_d = cnt - W'(1);
                            end
                        end
                    endcase
                end
                MODE_FROZEN: begin
                    dir_d = dir_q;
                    cnt_d = cnt;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= DIR_UP;
            cnt   <= '0;
        end else begin
            dir_q <= dir_d;
            cnt   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        zero_evt = run && (cnt == '0);
        prd_evt  = run && (cnt == act_prd);
    end

    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt)); // R2

    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FROZEN) |=> $stable(cnt)); // R6

    AST_DOWN_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (tick && mode == MODE_DOWN && cnt == '0) |=> (cnt == act_prd)); // R4

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_tbase_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] count,
    output logic         zero_evt,
    output logic         prd_evt
);
    cnt_mode_e          mode_q;
    logic               imm_q;
    logic [FIELD_W-1:0] hs_q;
    logic [FIELD_W-1:0] lo_q;
    logic               wr_ctrl;
    logic               wr_prd;
    logic               tick;
    logic [W-1:0]       act_prd;
    logic [W-1:0]       prd_next;
    logic               unused_ctrl_bits;

    assign wr_ctrl = wr_en && !wr_sel;
    assign wr_prd  = wr_en && wr_sel;
    assign unused_ctrl_bits = ^{wr_data[W-1:LO_LSB+FIELD_W],
                                wr_data[HS_LSB-1:PLD_BIT+1],
                                wr_data[PLD_BIT-1:MODE_LSB+2]};

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_UP;
            imm_q  <= 1'b0;
            hs_q   <= '0;
            lo_q   <= '0;
        end else if (wr_ctrl) begin
            mode_q <= cnt_mode_e'(wr_data[MODE_LSB +: 2]);
            imm_q  <= wr_data[PLD_BIT];
            hs_q   <= wr_data[HS_LSB +: FIELD_W];
            lo_q   <= wr_data[LO_LSB +: FIELD_W];
        end
    end

    pwm_prescaler #(.FIELD_W(FIELD_W)) u_presc (
        .clk    (clk),
        .rst    (rst),
        .hs_sel (hs_q),
        .lo_sel (lo_q),
        .tick   (tick)
    );

    pwm_period_reg #(.W(W)) u_prd (
        .clk      (clk),
        .rst      (rst),
        .wr_prd   (wr_prd),
        .wr_data  (wr_data),
        .imm_mode (imm_q),
        .load_req (zero_evt),
        .act_prd  (act_prd),
        .act_next (prd_next)
    );

    pwm_dir_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .mode     (mode_q),
        .prd_next (prd_next),
        .act_prd  (act_prd),
        .cnt      (count),
        .zero_evt (zero_evt),
        .prd_evt  (prd_evt)
    );

    AST_QUIET_WHEN_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_FROZEN) |-> (!zero_evt && !prd_evt)); // R6

endmodule

// File: tb/sim_pwm_timebase.sv
module sim_pwm_timebase;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] count;
    logic        zero_evt;
    logic        prd_evt;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference model state
    logic [15:0] m_ctrl;
    int          m_pc, m_cnt, m_act, m_sh;
    bit          m_up;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_timebase u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .count(count), .zero_evt(zero_evt), .prd_evt(prd_evt)
    );

    function automatic int ratio(input logic [15:0] c);
        int h = int'(c[9:7]);
        int l = int'(c[12:10]);
        return ((h == 0) ? 1 : 2 * h) << l;
    endfunction

    function automatic bit m_tick();
        return m_pc >= ratio(m_ctrl) - 1;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", req, what, cyc, act, exp);
        end
    endtask

    // behavioural reference, advanced on every edge
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_ctrl = '0; m_pc = 0; m_cnt = 0; m_act = 0; m_sh = 0; m_up = 1'b1;
        end else begin
            bit tk, imm, ld, live;
            int md, np;
            tk   = m_tick();
            md   = int'(m_ctrl[1:0]);
            imm  = m_ctrl[3];
            live = tk && (md != 3);
            ld   = live && (m_cnt == 0) && !imm;
            if (wr_en && wr_sel && imm) np = int'(wr_data);
            else if (ld)                np = m_sh;
            else                        np = m_act;
            if (live) begin
                if (md == 0) begin
                    m_up = 1'b1;
                    m_cnt = (m_cnt >= np) ? 0 : m_cnt + 1;
                end else if (md == 1) begin
                    m_up = 1'b0;
                    m_cnt = (m_cnt == 0) ? np : m_cnt - 1;
                end else if (m_up) begin
                    if (m_cnt >= np) begin
                        m_up = 1'b0;
                        if (m_cnt > 0) m_cnt = m_cnt - 1;
                    end else m_cnt = m_cnt + 1;
                end else begin
                    if (m_cnt == 0) begin
                        m_up = 1'b1;
                        m_cnt = (np == 0) ? 0 : 1;
                    end else m_cnt = m_cnt - 1;
                end
            end
            m_pc = tk ? 0 : m_pc + 1;
            if (wr_en && wr_sel)  m_sh = int'(wr_data);
            if (wr_en && !wr_sel) m_ctrl = wr_data;
            m_act = np;
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            bit live;
            live = m_tick() && (m_ctrl[1:0] != 2'b11);
            chk(cur_req, "count", int'(count), m_cnt);
            chk("R7", "zero_evt", int'(zero_evt), int'(live && m_cnt == 0));
            chk("R8", "prd_evt", int'(prd_evt), int'(live && m_cnt == m_act));
        end
    end

    always @(posedge clk) begin
        if (cyc > WDOG_LIMIT && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog (all requirements): actual=%0d cycles expected<%0d", cyc, WDOG_LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input bit sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        @(posedge clk);
        cmp_on = 1'b1;
        run(2);
        rst = 1'b0;
        cur_req = "R1";
        chk("R1", "count after reset", int'(count), 0);
        run(5);

        cur_req = "R11"; wr(0, 16'h0008); wr(1, 16'd5);     // up, immediate, P=5
        cur_req = "R3";  run(30);
        cur_req = "R9";  wr(1, 16'd2); run(12);
        cur_req = "R4";  wr(1, 16'd6); wr(0, 16'h0009); run(30);
        cur_req = "R5";  wr(0, 16'h000A); run(40);
        cur_req = "R2";  wr(0, 16'h0988); run(24 * 14);      // 6 x 4
        wr(0, 16'h0388); run(14 * 16);                       // 14 x 1
        wr(0, 16'h0C0A); run(8 * 20);                        // 1 x 8, up-down
        wr(0, 16'h1C08); run(128 * 3);                       // 1 x 128
        cur_req = "R6";  wr(0, 16'h000B); run(40);
        wr(0, 16'h0988); wr(0, 16'h098B); run(60);
        cur_req = "R10"; wr(0, 16'h0000); run(3); wr(1, 16'd3); run(30);
        wr(1, 16'd9); run(3); wr(0, 16'h0001); run(40);
        wr(1, 16'd1); run(30);
        cur_req = "R12"; wr(0, 16'h0008); wr(1, 16'd10); run(20);
        wr(1, 16'd4); run(20);
        cur_req = "R5";  wr(1, 16'd0); wr(0, 16'h000A); run(10);
        cur_req = "R3";  wr(0, 16'h0008); wr(1, 16'hFFFF); run(65540);
        cur_req = "R1";
        @(negedge clk); rst = 1'b1; run(2); rst = 1'b0;
        chk("R1", "count after mid-run reset", int'(count), 0);
        run(20);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule